// File: doc/BRIEF.md
# 10 Mb/s Transmit Jabber Guard

This block watches the transmit enable of a 10 Mb/s twisted-pair port and cuts it off when a single transmission runs for longer than the allowed 105 ms window. After such a cutoff the transmit path stays closed until the MAC has dropped its enable and kept it low for a programmable quiet gap. The window and the gap are given in microseconds and converted to clock cycles from a clock-frequency parameter.

Each cutoff also sets a sticky jabber flag. Management software sees this flag in two status registers. A read of either register returns the flag and then clears it, unless the port is still being held off at that moment. When the port runs at 100 Mb/s the guard is fully bypassed. Leaving 10 Mb/s mode in the middle of a frame discards the timer and releases any hold.

Top module: `jabber_guard`

## Requirements
- R1: While `rst_n` is low, `jab_flag` is 0 and `txen_out` equals `txen_in`. Asserting `rst_n` low clears a set flag at once, without waiting for a clock edge.
- R2: In 10 Mb/s mode (`speed_10`=1), when `txen_in` is held high, `txen_out` is high for exactly LIMIT_CYC clock cycles and then goes low while `txen_in` stays high. LIMIT_CYC = (CLK_HZ/1e6) x JAB_LIMIT_US.
- R3: A transmission in which `txen_in` is high for LIMIT_CYC cycles or fewer passes through unchanged and leaves `jab_flag` at 0.
- R4: The cycle after a cutoff, `jab_flag` reads 1. It stays 1 until a clearing read or a reset.
- R5: After a cutoff, `txen_out` stays low until `txen_in` has been sampled low on UNJAB_CYC consecutive clock edges. UNJAB_CYC = (CLK_HZ/1e6) x UNJAB_US. If `txen_in` rises earlier, the output stays blocked and the gap count starts again.
- R6: In 100 Mb/s mode (`speed_10`=0), `txen_out` equals `txen_in` in every cycle and `jab_flag` is never set.
- R7: A read (`rd_stb`=1) of address BASIC_ADDR (default 1) or EXT_ADDR (default 0x12) drives `rd_jab` with the current flag in the same cycle. The flag is 0 from the next edge on. A read of any other address returns `rd_jab`=0 and leaves the flag unchanged.
- R8: A clearing read does not clear the flag while the port is held off or is being cut off in that same cycle. In that case the flag is 1 after the read.
- R9: Leaving 10 Mb/s mode releases a hold at once. On return to 10 Mb/s with `txen_in` high, the timer restarts from zero and allows another full LIMIT_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| speed_10 | input | 1 | 1 = 10 Mb/s mode (guard active), 0 = 100 Mb/s (bypass) |
| txen_in | input | 1 | Transmit enable from the MAC |
| rd_stb | input | 1 | Register read strobe, one cycle per read |
| rd_addr | input | ADDR_W | Register address of the read |
| txen_out | output | 1 | Gated transmit enable to the line driver |
| jab_flag | output | 1 | Sticky jabber status |
| rd_jab | output | 1 | Jabber bit of the read data for the addressed register |

## Verification
A clearing read and the setting of the flag can happen on the same clock edge. This occurs when a read arrives on the exact cycle the timer reaches its limit, or while the port is still held off after a cutoff. The bench places a read of each of the two status addresses on the cutoff cycle, computed from LIMIT_CYC, and also during the hold. In both cases the read must return the old flag and the flag must read 1 on the next cycle. Reads made after the quiet gap has ended must clear the flag.

// File: rtl/jab_pkg.sv
package jab_pkg;

   typedef enum logic [1:0] {
      GS_OPEN = 2'd0,
      GS_JAB  = 2'd1,
      GS_GAP  = 2'd2
   } gate_state_e;

   function automatic int unsigned us_to_cycles(input int unsigned hz,
                                                input int unsigned us);
      return (hz / 1_000_000) * us;
   endfunction

endpackage

// File: rtl/jab_timer.sv
module jab_timer #(
   parameter int unsigned LIMIT_CYC = 1000,
   localparam int unsigned CNT_W    = $clog2(LIMIT_CYC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic over
);
   localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT_CYC);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (!run)       cnt <= '0;
      else if (cnt != LIM) cnt <= cnt + 1'b1;
   end

   assign over = run & (cnt == LIM);

   p_cnt_bound_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LIM);

   p_restart_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !over);

endmodule

// File: rtl/jab_gate.sv
module jab_gate
   import jab_pkg::*;
#(
   parameter int unsigned UNJAB_CYC = 8,
   localparam int unsigned UJ_W     = $clog2(UNJAB_CYC + 1),
   localparam bit FIRST_DONE        = (UNJAB_CYC == 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic speed_10,
   input  logic txen_in,
   input  logic over,
   output logic blocked
);
   gate_state_e st, st_nx;
   logic        gap_done;

   generate
      if (FIRST_DONE) begin : g_direct
         assign gap_done = 1'b1;
      end else begin : g_count
         logic [UJ_W-1:0] ucnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        ucnt <= '0;
            else if (st == GS_JAB)             ucnt <= UJ_W'(1);
            else if (st == GS_GAP && !txen_in) ucnt <= ucnt + 1'b1;
         end
         assign gap_done = (ucnt == UJ_W'(UNJAB_CYC - 1));
      end
   endgenerate

   always_comb begin
      st_nx = st;
      if (!speed_10) begin
         st_nx = GS_OPEN;
      end else begin
         unique case (st)
            GS_OPEN: if (over) st_nx = GS_JAB;
            GS_JAB:  if (!txen_in) st_nx = FIRST_DONE ? GS_OPEN : GS_GAP;
            GS_GAP:  if (txen_in) st_nx = GS_JAB;
                     else if (gap_done) st_nx = GS_OPEN;
            default: st_nx = GS_OPEN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= GS_OPEN;
      else        st <= st_nx;
   end

   assign blocked = (st != GS_OPEN);

   p_unjab_gap_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (st == GS_OPEN && $past(st) != GS_OPEN && $past(speed_10)) |-> $past(!txen_in));

   p_cut_enters_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (speed_10 && over) |=> (st != GS_OPEN || !speed_10 || $past(!speed_10)));

endmodule

// File: rtl/jab_status.sv
module jab_status #(
   parameter int unsigned ADDR_W  = 5,
   parameter int unsigned NUM_CLR = 2,
   parameter logic [NUM_CLR*ADDR_W-1:0] CLR_ADDRS = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_stb,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              cond,
   output logic              flag,
   output logic              rd_data
);
   logic [NUM_CLR-1:0] hit;
   logic               hit_any;

   generate
      for (genvar i = 0; i < NUM_CLR; i++) begin : g_dec
         assign hit[i] = rd_stb & (rd_addr == CLR_ADDRS[i*ADDR_W +: ADDR_W]);
      end
   endgenerate

   assign hit_any = |hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag <= 1'b0;
      else        flag <= cond | (flag & ~hit_any);
   end

   assign rd_data = hit_any & flag;

   p_clear_by_read_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag) |-> $past(hit_any));

   p_sticky_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !hit_any) |=> flag);

   p_hold_wins_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      cond |=> flag);

   p_one_hit_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit));

endmodule

// File: rtl/jabber_guard.sv
module jabber_guard
   import jab_pkg::*;
#(
   parameter int unsigned CLK_HZ       = 125_000_000,
   parameter int unsigned JAB_LIMIT_US = 105_000,
   parameter int unsigned UNJAB_US     = 500,
   parameter int unsigned ADDR_W       = 5,
   parameter int unsigned BASIC_ADDR   = 1,
   parameter int unsigned EXT_ADDR     = 18,
   localparam int unsigned LIMIT_CYC   = us_to_cycles(CLK_HZ, JAB_LIMIT_US),
   localparam int unsigned UNJAB_CYC   = us_to_cycles(CLK_HZ, UNJAB_US)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              speed_10,
   input  logic              txen_in,
   input  logic              rd_stb,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              txen_out,
   output logic              jab_flag,
   output logic              rd_jab
);
   localparam logic [2*ADDR_W-1:0] CLR_ADDRS = {ADDR_W'(EXT_ADDR), ADDR_W'(BASIC_ADDR)};

   initial begin
      assert (CLK_HZ >= 1_000_000) else $error("CLK_HZ below 1 MHz");
      assert (LIMIT_CYC >= 2) else $error("jabber window under 2 cycles");
      assert (UNJAB_CYC >= 1) else $error("quiet gap under 1 cycle");
      assert (BASIC_ADDR != EXT_ADDR) else $error("status addresses collide");
      assert (BASIC_ADDR < (1 << ADDR_W) && EXT_ADDR < (1 << ADDR_W))
         else $error("status address exceeds ADDR_W");
   end

   logic over, blocked, hold_cond;

   jab_timer #(.LIMIT_CYC(LIMIT_CYC)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (speed_10 & txen_in),
      .over  (over)
   );

   jab_gate #(.UNJAB_CYC(UNJAB_CYC)) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .speed_10 (speed_10),
      .txen_in  (txen_in),
      .over     (over),
      .blocked  (blocked)
   );

   assign hold_cond = speed_10 & (over | blocked);

   jab_status #(.ADDR_W(ADDR_W), .NUM_CLR(2), .CLR_ADDRS(CLR_ADDRS)) u_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_stb  (rd_stb),
      .rd_addr (rd_addr),
      .cond    (hold_cond),
      .flag    (jab_flag),
      .rd_data (rd_jab)
   );

   assign txen_out = txen_in & ~hold_cond;

   p_bypass_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      !speed_10 |-> (txen_out == txen_in));

   p_cut_flags_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(jab_flag) && speed_10) |-> !txen_out);

   p_fast_no_flag_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (!speed_10 && $past(!speed_10) && !$past(jab_flag)) |-> !jab_flag);

   p_out_implies_in_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      txen_out |-> txen_in);

endmodule

// File: tb/jabber_guard_bench.sv
module jabber_guard_bench;
   localparam int LIM  = 12;
   localparam int UJ   = 4;
   localparam int BAS  = 1;
   localparam int EXT  = 18;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       speed_10 = 1'b1;
   logic       txen_in = 1'b0;
   logic       rd_stb = 1'b0;
   logic [4:0] rd_addr = '0;
   logic       txen_out, jab_flag, rd_jab;

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;

   always #4 clk = ~clk;

   jabber_guard #(
      .CLK_HZ(1_000_000), .JAB_LIMIT_US(LIM), .UNJAB_US(UJ),
      .ADDR_W(5), .BASIC_ADDR(BAS), .EXT_ADDR(EXT)
   ) u_jabber_guard (
      .clk(clk), .rst_n(rst_n), .speed_10(speed_10), .txen_in(txen_in),
      .rd_stb(rd_stb), .rd_addr(rd_addr),
      .txen_out(txen_out), .jab_flag(jab_flag), .rd_jab(rd_jab)
   );

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0b expected %0b", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
   endtask

   task automatic rd(input int addr, output logic val);
      rd_stb  = 1'b1;
      rd_addr = 5'(addr);
      #1;
      val = rd_jab;
      tick();
      rd_stb = 1'b0;
      #1;
   endtask

   task automatic quiet_clear();
      logic v;
      txen_in = 1'b0;
      repeat (UJ + 2) tick();
      rd(BAS, v);
   endtask

   task automatic jab();
      txen_in = 1'b1;
      repeat (LIM + 2) tick();
   endtask

   initial begin
      logic v;
      // R1: reset state
      #1;
      chk("R1 flag in reset", jab_flag, 1'b0);
      txen_in = 1'b1;
      #1;
      chk("R1 pass in reset", txen_out, 1'b1);
      txen_in = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      #1;

      // R2/R3/R4: frame-length sweep
      for (int n = 1; n <= LIM + 3; n++) begin
         txen_in = 1'b1;
         #1;
         for (int k = 0; k < n; k++) begin
            chk($sformatf("R2 n=%0d k=%0d", n, k), txen_out, logic'(k < LIM));
            tick();
         end
         if (n > LIM) chk("R4 flag held while cut", jab_flag, 1'b1);
         txen_in = 1'b0;
         #1;
         chk($sformatf("R3 flag n=%0d", n), jab_flag, logic'(n > LIM));
         repeat (UJ + 1) tick();
         chk("R4 sticky", jab_flag, logic'(n > LIM));
         rd(BAS, v);
         chk("R7 read value", v, logic'(n > LIM));
         chk("R7 cleared", jab_flag, 1'b0);
      end

      // R5: quiet-gap sweep
      for (int l = 1; l <= UJ + 2; l++) begin
         jab();
         chk("R5 cut", txen_out, 1'b0);
         txen_in = 1'b0;
         repeat (l) tick();
         txen_in = 1'b1;
         #1;
         chk($sformatf("R5 gap=%0d", l), txen_out, logic'(l >= UJ));
         quiet_clear();
      end

      // R8: read while held, and read on the cutoff cycle
      jab();
      rd(EXT, v);
      chk("R8 read during hold value", v, 1'b1);
      chk("R8 flag kept during hold", jab_flag, 1'b1);
      quiet_clear();
      chk("R7 clear after gap", jab_flag, 1'b0);
      for (int a = 0; a < 2; a++) begin
         txen_in = 1'b1;
         repeat (LIM) tick();
         chk("R2 cutoff cycle", txen_out, 1'b0);
         rd(a == 0 ? BAS : EXT, v);
         chk("R8 clash read value", v, 1'b0);
         chk("R8 clash flag set", jab_flag, 1'b1);
         quiet_clear();
      end

      // R7: other addresses leave the flag alone
      jab();
      txen_in = 1'b0;
      repeat (UJ + 2) tick();
      for (int a = 0; a < 32; a++) begin
         if (a != BAS && a != EXT) begin
            rd(a, v);
            chk($sformatf("R7 addr %0d data", a), v, 1'b0);
            chk($sformatf("R7 addr %0d keep", a), jab_flag, 1'b1);
         end
      end
      rd(EXT, v);
      chk("R7 ext read value", v, 1'b1);
      chk("R7 ext cleared", jab_flag, 1'b0);

      // R6: 100 Mb/s bypass
      speed_10 = 1'b0;
      for (int k = 0; k < 3 * LIM; k++) begin
         txen_in = logic'((k % 7) != 0);
         #1;
         chk("R6 bypass", txen_out, txen_in);
         tick();
      end
      txen_in = 1'b1;
      repeat (2 * LIM) tick();
      chk("R6 long fast frame", txen_out, 1'b1);
      chk("R6 no flag", jab_flag, 1'b0);
      txen_in = 1'b0;
      speed_10 = 1'b1;
      tick();

      // R9: mode change while cut off, then mid-frame
      jab();
      chk("R9 cut before switch", txen_out, 1'b0);
      speed_10 = 1'b0;
      #1;
      chk("R9 released at once", txen_out, 1'b1);
      repeat (2) tick();
      speed_10 = 1'b1;
      #1;
      for (int k = 0; k <= LIM; k++) begin
         chk($sformatf("R9 restart k=%0d", k), txen_out, logic'(k < LIM));
         tick();
      end
      quiet_clear();
      txen_in = 1'b1;
      repeat (LIM - 2) tick();
      speed_10 = 1'b0;
      repeat (3) tick();
      speed_10 = 1'b1;
      #1;
      for (int k = 0; k <= LIM; k++) begin
         chk($sformatf("R9 mid-frame k=%0d", k), txen_out, logic'(k < LIM));
         tick();
      end

      // R1: asynchronous reset clears a set flag
      chk("R4 set before reset", jab_flag, 1'b1);
      #1;
      rst_n = 1'b0;
      #1;
      chk("R1 async clear", jab_flag, 1'b0);
      txen_in = 1'b0;
      tick();
      rst_n = 1'b1;

      done = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end
endmodule